// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block collects every reset request in a low-power microcontroller and produces one stretched system reset for the CPU and peripherals. Power-on, an external reset pin, a watchdog timeout, a sleep-counter timeout and a wake-up-on-change event are the requesters. Each one is a digital pulse or level; the analog checks, filters, oscillators and counters that raise them live elsewhere.

Which requests are honoured depends on the operating mode. The power-on request is always taken. The watchdog is taken only outside sleep. The sleep counter and wake-up events are taken only in sleep, and only when software has enabled each of them. The external pin passes through a digital debounce while the chip is awake. In sleep it is taken raw, because an analog filter in front of the block screens it there.

Power-on also drives a separate cold reset. The cold reset clears the sleep-enable latch and the power-on-only registers. It also sets a power-on status flag that software reads and clears. An ordinary system reset leaves this cold domain alone.

Top module: `sysrst_hub`

## Requirements
- R1: Any honoured request sampled at a clock edge makes `sys_rst` high from the next cycle on.
- R2: `sys_rst` stays high for exactly 12 cycles after the last edge that sampled an honoured request. A request that arrives while the reset is stretched restarts the 12-cycle count.
- R3: `cold_rst` rises only from `por_req`. It stays high for 12 cycles after the last edge that sampled `por_req`. `sys_rst` is high whenever `cold_rst` is high. `por_req` is honoured in every mode.
- R4: `sleep_en` is set by a one-cycle `sleep_set` strobe. It is cleared only while `por_req` or `cold_rst` is high. A system reset from any other source leaves `sleep_en` and `por_flag` unchanged.
- R5: The external pin (`pin_rst`, active high) has no effect while `pin_rst_en` is low.
- R6: When sleep gating is off, the pin counts only after it has been sampled high on two consecutive `deb_tick` cycles. The debounce history is cleared while `pin_rst_en` is low or `por_req` is high.
- R7: Sleep gating is on when `sleep_en` is 1 and `mode` equals 2'b10. Under sleep gating, `pin_rst` is taken raw with no debounce, and `wdog_req` is ignored. When gating is off (`mode` 2'b00 active, 2'b01 standby, or 2'b10 with `sleep_en` low), `wdog_req` is honoured.
- R8: `slpcnt_req` and `wake_req` are honoured only under sleep gating, and each only while its enable (`slpcnt_en`, `wake_en`) is high. Otherwise they are ignored.
- R9: `por_flag` is set by `por_req`. A `flag_clr` strobe clears it only in a cycle where `sys_rst` is low and `por_req` is low; while `sys_rst` is high the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on reset request, active high |
| pin_rst | input | 1 | External reset pin level, active high |
| pin_rst_en | input | 1 | Software enable for the pin reset |
| wdog_req | input | 1 | Watchdog timeout request |
| slpcnt_req | input | 1 | Sleep-counter timeout request |
| slpcnt_en | input | 1 | Software enable for the sleep-counter reset |
| wake_req | input | 1 | Wake-up-on-change event |
| wake_en | input | 1 | Software enable for wake-up reset |
| mode | input | 2 | Operating mode: 00 active, 01 standby, 10 sleep |
| deb_tick | input | 1 | One-cycle debounce sampling tap |
| sleep_set | input | 1 | Software strobe that sets the sleep-enable latch |
| flag_clr | input | 1 | Write-one-to-clear strobe for the power-on flag |
| sys_rst | output | 1 | Stretched system reset for the CPU and peripherals |
| cold_rst | output | 1 | Stretched power-on-only reset |
| por_flag | output | 1 | Power-on status flag |
| sleep_en | output | 1 | Sleep-enable latch |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a `flag_clr` strobe arrives while the stretched reset is still running. In the second, a new request arrives while an earlier stretch counts down. The bench fires the clear strobe once during the cold-reset stretch and once after `sys_rst` has dropped. It fires a second watchdog pulse midway through a stretch. A behavioural per-cycle model judges the flag and the reset length every cycle, and a directed count confirms the 12-cycle width.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int STRETCH_LEN = 12;
    localparam int DEB_DEPTH   = 2;

    typedef enum logic [1:0] {
        MD_ACTIVE  = 2'b00,
        MD_STANDBY = 2'b01,
        MD_SLEEP   = 2'b10,
        MD_RSVD    = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic por;
        logic pin_raw;
        logic pin_deb;
        logic pin_en;
        logic wdog;
        logic slpcnt;
        logic slpcnt_en;
        logic wake;
        logic wake_en;
    } req_bundle_t;

    function automatic logic sleep_gated(input logic latch, input logic [1:0] md);
        return latch && (op_mode_e'(md) == MD_SLEEP);
    endfunction

endpackage

// File: rtl/sysrst_debounce.sv
module sysrst_debounce #(
    parameter int DEPTH = sysrst_pkg::DEB_DEPTH
) (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    input  logic pin,
    output logic stable_hi
);
    logic [DEPTH-1:0] hist;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (clr)       hist <= '0;
                else if (tick) hist <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (clr)       hist <= '0;
                else if (tick) hist <= {hist[DEPTH-2:0], pin};
            end
        end
    endgenerate

    assign stable_hi = &hist;

    // R6: history only moves on a tick
    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (clr)
        (!tick && !$isunknown(hist)) |=> (clr || $stable(hist)));
endmodule

// File: rtl/sysrst_gate.sv
module sysrst_gate
    import sysrst_pkg::*;
(
    input  req_bundle_t rq,
    input  logic        sleep_mode,
    output logic        trig
);
    logic pin_hit, wd_hit, sc_hit, wk_hit;

    always_comb begin
        pin_hit = rq.pin_en && (sleep_mode ? rq.pin_raw : rq.pin_deb);
        wd_hit  = !sleep_mode && rq.wdog;
        sc_hit  = sleep_mode && rq.slpcnt_en && rq.slpcnt;
        wk_hit  = sleep_mode && rq.wake_en && rq.wake;
        trig    = rq.por || pin_hit || wd_hit || sc_hit || wk_hit;
    end

    // R5: a disabled pin never triggers alone
    always_comb begin
        if (!rq.pin_en && !rq.por && !rq.wdog && !rq.slpcnt && !rq.wake)
            a_pin_off_r5: assert (!trig);
    end
endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
    parameter int LEN = sysrst_pkg::STRETCH_LEN
) (
    input  logic clk,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (trig)             remain <= LOAD;
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign active = (remain != '0);

    // R2: a trigger always leaves the stretch fully loaded
    p_reload_r2: assert property (@(posedge clk) trig |=> remain == LOAD);
endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
    import sysrst_pkg::*;
#(
    parameter int HOLD_CYCLES = STRETCH_LEN,
    parameter int DEB_SAMPLES = DEB_DEPTH
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       pin_rst,
    input  logic       pin_rst_en,
    input  logic       wdog_req,
    input  logic       slpcnt_req,
    input  logic       slpcnt_en,
    input  logic       wake_req,
    input  logic       wake_en,
    input  logic [1:0] mode,
    input  logic       deb_tick,
    input  logic       sleep_set,
    input  logic       flag_clr,
    output logic       sys_rst,
    output logic       cold_rst,
    output logic       por_flag,
    output logic       sleep_en
);
    logic        pin_ok;
    logic        in_sleep;
    logic        any_trig;
    req_bundle_t bundle;

    sysrst_debounce #(.DEPTH(DEB_SAMPLES)) u_deb (
        .clk       (clk),
        .clr       (por_req || !pin_rst_en),
        .tick      (deb_tick),
        .pin       (pin_rst),
        .stable_hi (pin_ok)
    );

    always_comb begin
        in_sleep         = sleep_gated(sleep_en, mode);
        bundle.por       = por_req;
        bundle.pin_raw   = pin_rst;
        bundle.pin_deb   = pin_ok;
        bundle.pin_en    = pin_rst_en;
        bundle.wdog      = wdog_req;
        bundle.slpcnt    = slpcnt_req;
        bundle.slpcnt_en = slpcnt_en;
        bundle.wake      = wake_req;
        bundle.wake_en   = wake_en;
    end

    sysrst_gate u_gate (
        .rq         (bundle),
        .sleep_mode (in_sleep),
        .trig       (any_trig)
    );

    sysrst_stretch #(.LEN(HOLD_CYCLES)) u_sys (
        .clk    (clk),
        .trig   (any_trig),
        .active (sys_rst)
    );

    sysrst_stretch #(.LEN(HOLD_CYCLES)) u_cold (
        .clk    (clk),
        .trig   (por_req),
        .active (cold_rst)
    );

    always_ff @(posedge clk) begin
        if (por_req)                 por_flag <= 1'b1;
        else if (flag_clr && !sys_rst) por_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (por_req || cold_rst) sleep_en <= 1'b0;
        else if (sleep_set)      sleep_en <= 1'b1;
    end

    // R1: an honoured request raises the system reset next cycle
    p_trig_asserts_r1: assert property (@(posedge clk) disable iff (por_req)
        any_trig |=> sys_rst);
    // R3: the cold domain never runs without the system reset
    p_cold_in_sys_r3: assert property (@(posedge clk) disable iff (por_req)
        cold_rst |-> sys_rst);
    // R4: only the cold domain clears the sleep latch
    p_sleep_keep_r4: assert property (@(posedge clk) disable iff (por_req)
        (sleep_en && !cold_rst) |=> sleep_en);
    // R7: watchdog alone is ignored under sleep gating
    p_wdog_blocked_r7: assert property (@(posedge clk) disable iff (por_req)
        (in_sleep && wdog_req && !sys_rst && !(pin_rst_en && pin_rst)
         && !(slpcnt_en && slpcnt_req) && !(wake_en && wake_req)) |=> !sys_rst);
    // R9: the clear strobe works only outside the reset stretch
    p_flag_clr_r9: assert property (@(posedge clk) disable iff (por_req)
        (flag_clr && !sys_rst) |=> !por_flag);
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (por_req)
        (por_flag && sys_rst) |=> por_flag);
endmodule

// File: tb/tb_sysrst_hub.sv
module tb_sysrst_hub;
    logic clk = 1'b0;
    logic por_req = 1'b1, pin_rst = 1'b0, pin_rst_en = 1'b0, wdog_req = 1'b0;
    logic slpcnt_req = 1'b0, slpcnt_en = 1'b0, wake_req = 1'b0, wake_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic deb_tick = 1'b0, sleep_set = 1'b0, flag_clr = 1'b0;
    logic sys_rst, cold_rst, por_flag, sleep_en;

    always #4 clk = ~clk;

    sysrst_hub dut (.*);

    int    errors = 0, checks = 0;
    bit    armed = 0, tick_on = 0, done = 0;
    string phase = "R3";

    // behavioural reference state
    int m_sys = 0, m_cold = 0;
    bit m_flag = 0, m_sleep = 0;
    bit pin_q[$];

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit sg, deb, trig, sys_old, cold_old;
        sg   = m_sleep && (mode == 2'b10);
        deb  = (pin_q.size() >= 2) && pin_q[0] && pin_q[1];
        trig = por_req || (pin_rst_en && (sg ? pin_rst : deb)) || (!sg && wdog_req)
             || (sg && slpcnt_en && slpcnt_req) || (sg && wake_en && wake_req);
        sys_old  = (m_sys > 0);
        cold_old = (m_cold > 0);
        m_sys  = trig ? 12 : (m_sys > 0 ? m_sys - 1 : 0);
        m_cold = por_req ? 12 : (m_cold > 0 ? m_cold - 1 : 0);
        if (por_req) m_flag = 1;
        else if (flag_clr && !sys_old) m_flag = 0;
        if (por_req || cold_old) m_sleep = 0;
        else if (sleep_set) m_sleep = 1;
        if (por_req || !pin_rst_en) pin_q.delete();
        else if (deb_tick) begin
            pin_q.push_front(pin_rst);
            if (pin_q.size() > 2) void'(pin_q.pop_back());
        end
    end

    always @(negedge clk) begin
        #1;
        if (armed) begin
            chk(phase, "sys_rst", sys_rst, m_sys > 0);
            chk(phase, "cold_rst", cold_rst, m_cold > 0);
            chk(phase, "por_flag", por_flag, m_flag);
            chk(phase, "sleep_en", sleep_en, m_sleep);
        end
    end

    int tcnt = 0;
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % 4;
        deb_tick <= tick_on && (tcnt == 0);
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_wdog();
        wdog_req = 1; cyc(1); wdog_req = 0;
    endtask

    initial begin
        int n;
        cyc(3);
        por_req = 0;
        armed = 1;
        #2;
        // reset state: R3 power-on drives both resets and the flag
        chk("R3", "cold_rst after por", cold_rst, 1);
        chk("R9", "por_flag after por", por_flag, 1);
        chk("R4", "sleep_en after por", sleep_en, 0);
        phase = "R9";
        cyc(3); flag_clr = 1; cyc(1); flag_clr = 0; // during stretch: ignored
        #2 chk("R9", "flag kept during stretch", por_flag, 1);
        cyc(14);
        chk("R3", "cold_rst released", cold_rst, 0);
        flag_clr = 1; cyc(1); flag_clr = 0;
        #2 chk("R9", "flag cleared after stretch", por_flag, 0);
        // R4: set the sleep latch, then an ordinary reset must keep it
        phase = "R4";
        sleep_set = 1; cyc(1); sleep_set = 0; cyc(1);
        // R1/R2 single watchdog pulse, count width
        phase = "R2";
        pulse_wdog();
        n = 0;
        while (sys_rst && n < 100) begin n++; cyc(1); end
        chk("R2", "stretch width", n, 12);
        chk("R4", "sleep_en kept after watchdog reset", sleep_en, 1);
        // R2 retrigger mid stretch
        pulse_wdog(); cyc(5); pulse_wdog();
        n = 0;
        while (sys_rst && n < 100) begin n++; cyc(1); end
        chk("R2", "retriggered stretch width", n, 12);
        // R5 pin without enable (mode 01 standby, gating off)
        phase = "R5";
        mode = 2'b01; tick_on = 1;
        pin_rst = 1; cyc(20); pin_rst = 0; cyc(2);
        chk("R5", "disabled pin ignored", sys_rst, 0);
        // R6 debounce: short blip then held level
        phase = "R6";
        pin_rst_en = 1; cyc(2);
        pin_rst = 1; cyc(2); pin_rst = 0; cyc(10);
        pin_rst = 1; cyc(14); pin_rst = 0; cyc(20);
        // R7 sleep gating: watchdog ignored, raw pin
        phase = "R7";
        mode = 2'b10; tick_on = 0; cyc(2);
        pulse_wdog(); cyc(2);
        chk("R7", "watchdog ignored in sleep", sys_rst, 0);
        pin_rst = 1; cyc(1); pin_rst = 0; cyc(1);
        chk("R7", "raw pin honoured in sleep", sys_rst, 1);
        cyc(14);
        // R8 sleep counter and wake
        phase = "R8";
        pin_rst_en = 0;
        slpcnt_req = 1; cyc(1); slpcnt_req = 0; cyc(2);
        chk("R8", "sleep counter without enable", sys_rst, 0);
        slpcnt_en = 1; slpcnt_req = 1; cyc(1); slpcnt_req = 0; cyc(14);
        wake_req = 1; cyc(1); wake_req = 0; cyc(2);
        chk("R8", "wake without enable", sys_rst, 0);
        wake_en = 1; wake_req = 1; cyc(1); wake_req = 0; cyc(1);
        chk("R8", "wake honoured in sleep", sys_rst, 1);
        cyc(14);
        mode = 2'b00;
        slpcnt_req = 1; wake_req = 1; cyc(1); slpcnt_req = 0; wake_req = 0; cyc(2);
        chk("R8", "sleep sources ignored when active", sys_rst, 0);
        // R1 watchdog in mode 10 with latch cleared by new power-on
        phase = "R4";
        por_req = 1; cyc(1); por_req = 0; cyc(14);
        chk("R4", "sleep_en cleared by power-on", sleep_en, 0);
        phase = "R1";
        mode = 2'b10; cyc(1);
        pulse_wdog(); cyc(1);
        chk("R1", "watchdog honoured when latch clear", sys_rst, 1);
        cyc(15);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule